// File: doc/BRIEF.md
# Lane-wise vector byte right shifter

This block is a one-stage SIMD execution unit. It shifts a 512-bit vector operand right by a whole number of bytes and fills the vacated bytes with zeros. The shift never crosses a 128-bit lane boundary: every active lane is shifted on its own by the same byte count. The count is an 8-bit unsigned immediate. Any count above 15 is treated as 16, so each active lane comes out as all zeros.

A 2-bit mode input selects how many lanes take part and what happens to the bits above them. Mode 00 is the legacy 128-bit form. Its operand is the old destination value, and bits 511:128 keep their old contents. Mode 01 shifts one lane and clears everything above it. Mode 10 shifts two lanes and clears bits 511:256. Mode 11 shifts all four lanes.

The result is captured in an output register together with a valid flag. It appears one clock after the operation is presented. The register loads only on cycles where the input strobe is high. The unit raises no flags and no exceptions.

Top module: `vbyte_rshift_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. A synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R2: For a count n from 0 to 15, byte i of each shifted lane (byte 0 = bits 7:0 of the lane) equals operand byte i+n of the same lane when i+n < 16, and is zero otherwise.
- R3: Any count from 16 to 255 produces all zeros in every shifted lane.
- R4: No byte moves from one 128-bit lane into another. The top byte of a lane shifted by a nonzero count is zero, whatever the neighbouring lane holds.
- R5: In mode 00, lane 0 is shifted from `old_dst[127:0]`, `src` is ignored, and `result[511:128]` equals `old_dst[511:128]`.
- R6: In mode 01, lane 0 is shifted from `src[127:0]` and `result[511:128]` is zero.
- R7: In mode 10, lanes 0 and 1 are shifted from `src[255:0]` and `result[511:256]` is zero.
- R8: In mode 11, all four lanes of `src` are shifted with the same count.
- R9: On a cycle with `in_valid` low, `result` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | 00 legacy 128, 01 vector 128, 10 vector 256, 11 vector 512 |
| shamt | input | 8 | Byte shift count, unsigned |
| src | input | 512 | Source vector (used in modes 01, 10, 11) |
| old_dst | input | 512 | Previous destination value (operand and upper bits in mode 00) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 512 | Registered shifted vector |

## Verification
The assertions assume that `mode`, `shamt`, `src` and `old_dst` are stable, known values on every cycle where `in_valid` is high. They also assume that `rst` is held for at least one clock before the first operation.

The stimulus keeps to these assumptions. It changes inputs only on the falling clock edge, and it always drives all four operand inputs with defined values. It sweeps every count from 0 to 255 in each mode with random operand data. It adds directed patterns with distinct bytes per lane, so that any byte crossing a lane boundary is caught. Idle cycles scramble the operands to exercise the hold behaviour.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    localparam int VEC_W      = 512;
    localparam int LANE_W     = 128;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 8;
    localparam int NUM_LANES  = VEC_W / LANE_W;
    localparam int LANE_BYTES = LANE_W / BYTE_W;
    localparam int AMT_W      = $clog2(LANE_BYTES + 1);

    typedef enum logic [1:0] {
        MODE_KEEP128 = 2'b00,
        MODE_ZERO128 = 2'b01,
        MODE_ZERO256 = 2'b10,
        MODE_FULL512 = 2'b11
    } vmode_e;

    typedef enum logic [1:0] {
        LANE_SHIFT = 2'b00,
        LANE_CLEAR = 2'b01,
        LANE_HOLD  = 2'b10
    } lane_act_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } vres_t;

    // Number of 128-bit lanes that take part in the shift for a mode.
    function automatic int lanes_in_use(vmode_e m);
        case (m)
            MODE_ZERO256: return 2;
            MODE_FULL512: return NUM_LANES;
            default:      return 1;
        endcase
    endfunction

    // What a given lane does under a mode: shift, clear, or keep old contents.
    function automatic lane_act_e lane_action(vmode_e m, int idx);
        if (idx < lanes_in_use(m))
            return LANE_SHIFT;
        else if (m == MODE_KEEP128)
            return LANE_HOLD;
        else
            return LANE_CLEAR;
    endfunction

endpackage

// File: rtl/vbs_count_sat.sv
module vbs_count_sat #(
    parameter int CNT_W      = 8,
    parameter int LANE_BYTES = 16,
    localparam int AMT_W     = $clog2(LANE_BYTES + 1)
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [AMT_W-1:0] amt,
    output logic             sat
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LANE_BYTES - 1);

    always_comb begin
        sat = (cnt > LIMIT);
        amt = sat ? AMT_W'(LANE_BYTES) : cnt[AMT_W-1:0];
    end
endmodule

// File: rtl/vbs_lane_shift.sv
module vbs_lane_shift #(
    parameter int BYTE_W     = 8,
    parameter int LANE_BYTES = 16,
    localparam int LANE_W    = BYTE_W * LANE_BYTES,
    localparam int AMT_W     = $clog2(LANE_BYTES + 1)
) (
    input  logic [LANE_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    output logic [LANE_W-1:0] dout
);
    logic [LANE_W-1:0] stg [AMT_W+1];

    assign stg[0] = din;

    // Logarithmic byte shifter: stage k moves by 2**k bytes.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = BYTE_W * (2 ** k);
        if (SH >= LANE_W) begin : g_clear
            assign stg[k+1] = amt[k] ? '0 : stg[k];
        end else begin : g_move
            assign stg[k+1] = amt[k] ? (stg[k] >> SH) : stg[k];
        end
    end

    assign dout = stg[AMT_W];
endmodule

// File: rtl/vbs_lane_merge.sv
module vbs_lane_merge
    import vbs_pkg::*;
#(
    parameter int W = 128
) (
    input  lane_act_e      act,
    input  logic [W-1:0]   shifted,
    input  logic [W-1:0]   kept,
    output logic [W-1:0]   dout
);
    always_comb begin
        case (act)
            LANE_SHIFT: dout = shifted;
            LANE_HOLD:  dout = kept;
            default:    dout = '0;
        endcase
    end
endmodule

// File: rtl/vbyte_rshift_unit.sv
module vbyte_rshift_unit
    import vbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [CNT_W-1:0]     shamt,
    input  logic [VEC_W-1:0]     src,
    input  logic [VEC_W-1:0]     old_dst,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result
);
    vmode_e           mode_e;
    logic [VEC_W-1:0] opnd;
    logic [VEC_W-1:0] next_data;
    logic [AMT_W-1:0] amt;
    logic             cnt_sat;
    vres_t            res_q;

    assign mode_e = vmode_e'(mode);
    assign opnd   = (mode_e == MODE_KEEP128) ? old_dst : src;

    vbs_count_sat #(
        .CNT_W      (CNT_W),
        .LANE_BYTES (LANE_BYTES)
    ) i_sat (
        .cnt (shamt),
        .amt (amt),
        .sat (cnt_sat)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] shifted;
        lane_act_e         act;

        assign act = lane_action(mode_e, g);

        vbs_lane_shift #(
            .BYTE_W     (BYTE_W),
            .LANE_BYTES (LANE_BYTES)
        ) i_shift (
            .din  (opnd[g*LANE_W +: LANE_W]),
            .amt  (amt),
            .dout (shifted)
        );

        vbs_lane_merge #(
            .W (LANE_W)
        ) i_merge (
            .act     (act),
            .shifted (shifted),
            .kept    (old_dst[g*LANE_W +: LANE_W]),
            .dout    (next_data[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= in_valid;
            if (in_valid)
                res_q.data <= next_data;
        end
    end

    assign out_valid = res_q.vld;
    assign result    = res_q.data;

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    sat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt_sat) |=> (result[LANE_W-1:0] == '0));
    // R4
    lane_top_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b11 && shamt != '0)
            |=> (result[VEC_W-1 -: BYTE_W] == '0 && result[LANE_W-1 -: BYTE_W] == '0));
    // R5
    legacy_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00)
            |=> (result[VEC_W-1:LANE_W] == $past(old_dst[VEC_W-1:LANE_W])));
    // R6
    zero128_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01) |=> (result[VEC_W-1:LANE_W] == '0));
    // R7
    zero256_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10) |=> (result[VEC_W-1:2*LANE_W] == '0));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
endmodule

// File: tb/test_vbyte_rshift_unit.sv
module test_vbyte_rshift_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [7:0]   shamt = '0;
    logic [511:0] src = '0;
    logic [511:0] old_dst = '0;
    logic         out_valid;
    logic [511:0] result;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbyte_rshift_unit i_vbyte_rshift_unit (
        .clk, .rst, .in_valid, .mode, .shamt, .src, .old_dst, .out_valid, .result
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Byte-by-byte expectation derived from R2..R8.
    function automatic logic [511:0] expect_of(logic [1:0] m, logic [7:0] c,
                                               logic [511:0] s, logic [511:0] o);
        logic [511:0] e;
        logic [511:0] op;
        int n;
        int used;
        n    = (c > 15) ? 16 : int'(c);
        used = (m == 2'b11) ? 4 : (m == 2'b10) ? 2 : 1;
        op   = (m == 2'b00) ? o : s;
        e    = '0;
        for (int ln = 0; ln < 4; ln++) begin
            for (int b = 0; b < 16; b++) begin
                if (ln < used)
                    e[ln*128 + b*8 +: 8] = (b + n < 16) ? op[ln*128 + (b+n)*8 +: 8] : 8'h00;
                else if (m == 2'b00)
                    e[ln*128 + b*8 +: 8] = o[ln*128 + b*8 +: 8];
            end
        end
        return e;
    endfunction

    task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [7:0] c,
                          input logic [511:0] s, input logic [511:0] o,
                          input string tag);
        logic [511:0] e;
        e = expect_of(m, c, s, o);
        @(negedge clk);
        mode = m; shamt = c; src = s; old_dst = o; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R1 valid"}, {511'b0, out_valid}, 512'd1);
        chk(tag, result, e);
    endtask

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00:   return "R5";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [511:0] pat;
        logic [511:0] prev;
        void'($urandom(32'h1BADF00D));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 reset valid", {511'b0, out_valid}, '0);
        chk("R1 reset data", result, '0);

        // Full sweep: every count in every mode (R2, R3 and mode tags)
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 256; c++) begin
                run_op(2'(m), 8'(c), rnd512(), rnd512(),
                       {(c > 15) ? "R3/" : "R2/", mode_tag(2'(m))});
            end
        end

        // R4: distinct bytes per lane, check no byte crosses a lane
        for (int i = 0; i < 64; i++) pat[i*8 +: 8] = 8'(i + 1);
        for (int c = 1; c < 16; c++) begin
            run_op(2'b11, 8'(c), pat, rnd512(), "R4 lanes");
            for (int ln = 0; ln < 4; ln++)
                chk("R4 top byte", {504'b0, result[ln*128 + 120 +: 8]}, '0);
        end

        // R5: src ignored in legacy mode
        pat = rnd512();
        run_op(2'b00, 8'd3, rnd512(), pat, "R5 srcA");
        prev = result;
        run_op(2'b00, 8'd3, ~src, pat, "R5 srcB");
        chk("R5 src ignored", result, prev);

        // Boundary counts with all-ones data
        run_op(2'b11, 8'd15, '1, '0, "R2 c15");
        run_op(2'b11, 8'd16, '1, '0, "R3 c16");
        run_op(2'b10, 8'd255, '1, '1, "R3/R7 c255");
        run_op(2'b00, 8'd0, '0, '1, "R5 c0");

        // R9: idle cycles hold the result
        for (int k = 0; k < 40; k++) begin
            run_op(2'($urandom_range(3)), 8'($urandom_range(20)), rnd512(), rnd512(), "R2 rnd");
            prev = result;
            @(negedge clk);
            mode = 2'($urandom); shamt = 8'($urandom); src = rnd512(); old_dst = rnd512();
            @(negedge clk);
            chk("R9 hold", result, prev);
            chk("R1 idle valid", {511'b0, out_valid}, '0);
        end

        // R1: reset clears after activity
        run_op(2'b11, 8'd1, '1, '1, "R8 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 re-reset data", result, '0);

        summary();
        $finish;
    end
endmodule